// File: doc/BRIEF.md
# I2C DMA request and last-byte control

This block sits between the data register of an I2C controller and one DMA stream. Byte-level events from the shift engine are turned into a level DMA request. In transmit, the request follows a "data register emptied" event. In receive, it follows a "data register filled" event. Each request is held until the DMA touches the data register, and then a short gap is enforced before the next request. A byte that completes while a request is still open raises a sticky overrun/underrun flag and a clock-stretch request.

The block watches the stream's two end-of-transfer pulses. The final pulse marks the transfer complete, and in transmit it shuts off further requests. The early pulse, which comes at the next-to-last byte of a receive, forces a NACK when the last-byte control bit is set. For a single-byte receive, software clears the ACK bit while the address flag is still pending.

Software STOP writes are gated. In master transmit with DMA active, a STOP waits until the transfer is complete and the byte-finished flag is set. Otherwise a STOP waits only for the address flag to clear. The buffer interrupt enable is masked whenever DMA drives a transmit.

Top module: `i2c_dma_ctl`

## Requirements
- R1: The request output rises one cycle after a data event only if DMA is enabled and the event matches the direction. A transmit uses the empty event and a receive uses the full event. Any other event leaves the request low.
- R2: A raised request stays high until a data-register access. After that access it stays low for exactly GAP_CYCLES+1 cycles (2 at the default). A data event seen while the request was high is remembered and re-raises the request once the gap ends.
- R3: A byte completion while a request is open sets the error flag and the stretch output in the next cycle. The stretch output holds until a data-register access. The error flag holds until the address-clear pulse.
- R4: The final end-of-transfer pulse sets the transfer-complete output from the next cycle until the address-clear pulse. In transmit mode, no request is raised in that window.
- R5: In receive mode with the last-byte bit at 1, the early end-of-transfer pulse drives the ACK decision to 0 (NACK) from the next cycle until the address-clear pulse. With the last-byte bit at 0, the pulse has no effect on the ACK decision.
- R6: When no forced NACK is latched, the ACK decision (1 = ACK, 0 = NACK) equals the software ACK bit. Clearing that bit while the address flag is high therefore NACKs the single byte of a one-byte receive.
- R7: In master transmit with DMA enabled, a STOP write is held and the stop-pending output is set. The STOP pulse (one cycle) is issued in the cycle after the transfer is complete and the byte-finished flag is high, and the stop-pending output then drops.
- R8: In any other mode, a STOP write gives a one-cycle STOP pulse in the next cycle if the address flag is low. If the address flag is high, the STOP is held (stop-pending set) until the flag falls.
- R9: The effective buffer interrupt enable equals the software enable, masked to 0 whenever DMA is enabled in transmit mode.
- R10: After reset, the request, STOP, stop-pending, transfer-complete, error and stretch outputs are all 0, and no NACK is forced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dma_en_i | input | 1 | DMA enable control bit |
| buf_ie_i | input | 1 | Software buffer interrupt enable |
| tx_mode_i | input | 1 | 1 = transmitter, 0 = receiver |
| master_i | input | 1 | 1 = master mode |
| ack_i | input | 1 | Software ACK bit |
| last_i | input | 1 | Last-byte NACK enable |
| addr_i | input | 1 | Address-matched flag (level) |
| btf_i | input | 1 | Byte-transfer-finished flag (level) |
| addr_clr_i | input | 1 | Address flag clear pulse, starts a new transfer |
| txe_set_i | input | 1 | Data register became empty (pulse) |
| rxne_set_i | input | 1 | Data register became full (pulse) |
| dr_access_i | input | 1 | DMA access of the data register (pulse) |
| byte_done_i | input | 1 | Byte finished on the bus (pulse) |
| eot_i | input | 1 | Final end-of-transfer pulse from DMA |
| eot1_i | input | 1 | Early end-of-transfer pulse (next-to-last byte) |
| stop_wr_i | input | 1 | Software STOP write pulse |
| dma_req_o | output | 1 | DMA request level |
| ack_o | output | 1 | ACK decision for the next received byte |
| stop_o | output | 1 | STOP request pulse to the bit engine |
| stop_pend_o | output | 1 | A STOP write is deferred |
| xfer_done_o | output | 1 | Transfer complete |
| ovr_o | output | 1 | Overrun (receive) / underrun (transmit) |
| stretch_o | output | 1 | Clock-stretch request |
| buf_irq_en_o | output | 1 | Effective buffer interrupt enable |

## Verification
The hardest case to reach is the deferred STOP in master transmit. It needs three things to overlap: a STOP write, then a byte-finished flag with no end-of-transfer yet, and then the end-of-transfer pulse. The stimulus arranges them in that order, so the STOP is seen to stay held while the byte-finished flag is high, and it is released exactly one cycle after the completion flag registers. A second hard case is a data event that arrives while a request is still held. The bench issues it before the access and then counts the gap cycles until the remembered request rises again.

// File: rtl/i2c_dma_pkg.sv
package i2c_dma_pkg;
  typedef struct packed {
    logic dma_en;
    logic tx;
    logic master;
  } xfer_ctl_t;
endpackage

// File: rtl/i2c_dma_req.sv
module i2c_dma_req #(
  parameter int unsigned GAP_CYCLES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dma_en_i,
  input  logic tx_mode_i,
  input  logic block_i,
  input  logic txe_set_i,
  input  logic rxne_set_i,
  input  logic dr_access_i,
  input  logic byte_done_i,
  input  logic addr_clr_i,
  output logic req_o,
  output logic ovr_o,
  output logic stretch_o
);
  logic evt, gap_act, req_q, pend_q, rise, ack_hit, ovr_q, stretch_q;

  assign evt     = dma_en_i & ~block_i & (tx_mode_i ? txe_set_i : rxne_set_i);
  assign ack_hit = req_q & dr_access_i;
  assign rise    = ~req_q & ~gap_act & dma_en_i & ~block_i & (evt | pend_q);

  generate
    if (GAP_CYCLES > 0) begin : g_gap
      localparam int unsigned GW = $clog2(GAP_CYCLES + 1);
      logic [GW-1:0] gap_cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              gap_cnt_q <= '0;
        else if (ack_hit)         gap_cnt_q <= GW'(GAP_CYCLES);
        else if (gap_cnt_q != '0) gap_cnt_q <= gap_cnt_q - 1'b1;
      end
      assign gap_act = (gap_cnt_q != '0);

      // R2: at least one more idle cycle after the falling edge
      a_r2_gap_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(req_q) |=> !req_q);
    end else begin : g_nogap
      assign gap_act = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (rise)         req_q <= 1'b1;
      else if (ack_hit) req_q <= 1'b0;
      if (block_i || !dma_en_i || rise) pend_q <= 1'b0;
      else if (evt)                     pend_q <= 1'b1;
    end
  end

  // byte finished with data register not serviced
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q     <= 1'b0;
      stretch_q <= 1'b0;
    end else if (byte_done_i && (req_q || pend_q)) begin
      ovr_q     <= 1'b1;
      stretch_q <= 1'b1;
    end else begin
      if (dr_access_i) stretch_q <= 1'b0;
      if (addr_clr_i)  ovr_q     <= 1'b0;
    end
  end

  assign req_o     = req_q;
  assign ovr_o     = ovr_q;
  assign stretch_o = stretch_q;

  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && !dr_access_i |=> req_q);
  a_r1_req_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(dma_en_i));
  a_r3_stretch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stretch_q && !dr_access_i |=> stretch_q);
endmodule

// File: rtl/i2c_dma_trk.sv
module i2c_dma_trk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_mode_i,
  input  logic last_i,
  input  logic ack_i,
  input  logic eot_i,
  input  logic eot1_i,
  input  logic addr_clr_i,
  output logic eot_seen_o,
  output logic ack_o
);
  logic eot_seen_q, nack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eot_seen_q <= 1'b0;
      nack_q     <= 1'b0;
    end else begin
      if (eot_i)           eot_seen_q <= 1'b1;
      else if (addr_clr_i) eot_seen_q <= 1'b0;
      if (eot1_i && !tx_mode_i && last_i) nack_q <= 1'b1;
      else if (addr_clr_i)                nack_q <= 1'b0;
    end
  end

  assign eot_seen_o = eot_seen_q;
  assign ack_o      = ack_i & ~nack_q;

  a_r5_nack_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_q && !addr_clr_i |=> !ack_o);
  a_r4_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eot_seen_q && !addr_clr_i |=> eot_seen_q);
endmodule

// File: rtl/i2c_dma_stop.sv
module i2c_dma_stop
  import i2c_dma_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  xfer_ctl_t ctl_i,
  input  logic      addr_i,
  input  logic      btf_i,
  input  logic      eot_seen_i,
  input  logic      stop_wr_i,
  output logic      stop_o,
  output logic      pend_o
);
  logic defer_tx, release_ok, want, stop_q, pend_q;

  assign defer_tx   = ctl_i.master & ctl_i.tx & ctl_i.dma_en;
  assign release_ok = defer_tx ? (eot_seen_i & btf_i) : ~addr_i;
  assign want       = stop_wr_i | pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      stop_q <= want & release_ok;
      pend_q <= want & ~release_ok;
    end
  end

  assign stop_o = stop_q;
  assign pend_o = pend_q;

  a_r7_stop_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    defer_tx && !(eot_seen_i && btf_i) |=> !stop_q);
  a_r8_stop_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !defer_tx && addr_i |=> !stop_q);
endmodule

// File: rtl/i2c_dma_ctl.sv
module i2c_dma_ctl
  import i2c_dma_pkg::*;
#(
  parameter int unsigned GAP_CYCLES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dma_en_i,
  input  logic buf_ie_i,
  input  logic tx_mode_i,
  input  logic master_i,
  input  logic ack_i,
  input  logic last_i,
  input  logic addr_i,
  input  logic btf_i,
  input  logic addr_clr_i,
  input  logic txe_set_i,
  input  logic rxne_set_i,
  input  logic dr_access_i,
  input  logic byte_done_i,
  input  logic eot_i,
  input  logic eot1_i,
  input  logic stop_wr_i,
  output logic dma_req_o,
  output logic ack_o,
  output logic stop_o,
  output logic stop_pend_o,
  output logic xfer_done_o,
  output logic ovr_o,
  output logic stretch_o,
  output logic buf_irq_en_o
);
  xfer_ctl_t ctl;
  logic      eot_seen, tx_block;

  assign ctl.dma_en = dma_en_i;
  assign ctl.tx     = tx_mode_i;
  assign ctl.master = master_i;
  assign tx_block   = eot_seen & tx_mode_i;

  // TxE interrupt must not compete with the DMA request
  assign buf_irq_en_o = buf_ie_i & ~(dma_en_i & tx_mode_i);

  i2c_dma_trk u_trk (
    .clk_i, .rst_ni,
    .tx_mode_i, .last_i, .ack_i, .eot_i, .eot1_i, .addr_clr_i,
    .eot_seen_o (eot_seen),
    .ack_o
  );

  i2c_dma_req #(.GAP_CYCLES(GAP_CYCLES)) u_req (
    .clk_i, .rst_ni,
    .dma_en_i, .tx_mode_i,
    .block_i    (tx_block),
    .txe_set_i, .rxne_set_i, .dr_access_i, .byte_done_i, .addr_clr_i,
    .req_o      (dma_req_o),
    .ovr_o,
    .stretch_o
  );

  i2c_dma_stop u_stop (
    .clk_i, .rst_ni,
    .ctl_i      (ctl),
    .addr_i, .btf_i,
    .eot_seen_i (eot_seen),
    .stop_wr_i,
    .stop_o,
    .pend_o     (stop_pend_o)
  );

  assign xfer_done_o = eot_seen;

  a_r4_no_req_after_eot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_req_o) |-> !$past(tx_block));
endmodule

// File: tb/sim_i2c_dma_ctl.sv
module sim_i2c_dma_ctl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] P_TXE = 8'h01, P_RXNE = 8'h02, P_ACC = 8'h04,
                         P_BYTE = 8'h08, P_EOT = 8'h10, P_EOT1 = 8'h20,
                         P_STOP = 8'h40, P_ACLR = 8'h80;
  // {buf_ie, dma_en, tx, ack_i, exp_irq_en, exp_ack}
  localparam logic [5:0] VEC [8] = '{
    6'b000_0_0_0, 6'b100_1_1_1, 6'b101_0_1_0, 6'b110_1_1_1,
    6'b111_1_0_1, 6'b011_0_0_0, 6'b111_0_0_0, 6'b010_1_0_1};

  logic clk = 0, rst_ni = 0;
  logic dma_en = 0, buf_ie = 0, tx = 0, master = 1, ack = 1, last = 0;
  logic addr = 0, btf = 0;
  logic [7:0] pv = '0;
  logic dma_req, ack_o, stop, stop_pend, xfer_done, ovr, stretch, irq_en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_dma_ctl u0 (
    .clk_i(clk), .rst_ni, .dma_en_i(dma_en), .buf_ie_i(buf_ie), .tx_mode_i(tx),
    .master_i(master), .ack_i(ack), .last_i(last), .addr_i(addr), .btf_i(btf),
    .addr_clr_i(pv[7]), .txe_set_i(pv[0]), .rxne_set_i(pv[1]), .dr_access_i(pv[2]),
    .byte_done_i(pv[3]), .eot_i(pv[4]), .eot1_i(pv[5]), .stop_wr_i(pv[6]),
    .dma_req_o(dma_req), .ack_o, .stop_o(stop), .stop_pend_o(stop_pend),
    .xfer_done_o(xfer_done), .ovr_o(ovr), .stretch_o(stretch), .buf_irq_en_o(irq_en));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse(input logic [7:0] m);
    pv = m;
    @(negedge clk);
    pv = '0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R10 actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(2);
    rst_ni = 1;
    step(1);
    // R10 reset state
    chk("R10 req", dma_req, 0); chk("R10 stop", stop, 0);
    chk("R10 pend", stop_pend, 0); chk("R10 done", xfer_done, 0);
    chk("R10 ovr", ovr, 0); chk("R10 stretch", stretch, 0);
    chk("R10 ack", ack_o, 1);

    // R9 and R6 table
    for (int k = 0; k < 8; k++) begin
      {buf_ie, dma_en, tx, ack} = VEC[k][5:2];
      #1;
      chk("R9 irq_en", irq_en, VEC[k][1]);
      chk("R6 ack", ack_o, VEC[k][0]);
      step(1);
    end
    buf_ie = 0; ack = 1;

    // R1
    tx = 1; dma_en = 0;
    pulse(P_TXE);  chk("R1 no en", dma_req, 0);
    dma_en = 1;
    pulse(P_RXNE); chk("R1 wrong dir", dma_req, 0);
    pulse(P_TXE);  chk("R1 tx req", dma_req, 1);

    // R2 hold, pending event, gap
    step(3);       chk("R2 hold", dma_req, 1);
    pulse(P_TXE);  chk("R2 hold evt", dma_req, 1);
    pulse(P_ACC);  chk("R2 drop", dma_req, 0);
    step(1);       chk("R2 gap", dma_req, 0);
    step(1);       chk("R2 re-raise", dma_req, 1);
    pulse(P_ACC);  step(2); chk("R2 idle", dma_req, 0);

    // R3
    pulse(P_TXE);  chk("R3 req", dma_req, 1);
    pulse(P_BYTE); chk("R3 ovr", ovr, 1); chk("R3 stretch", stretch, 1);
    step(2);       chk("R3 stretch hold", stretch, 1);
    pulse(P_ACC);  chk("R3 stretch clr", stretch, 0); chk("R3 ovr hold", ovr, 1);
    pulse(P_ACLR); chk("R3 ovr clr", ovr, 0);
    step(2);

    // R4
    pulse(P_EOT);  chk("R4 done", xfer_done, 1);
    pulse(P_TXE);  chk("R4 blocked", dma_req, 0);
    step(1);       chk("R4 blocked2", dma_req, 0);
    pulse(P_ACLR); chk("R4 done clr", xfer_done, 0);
    pulse(P_TXE);  chk("R4 req again", dma_req, 1);
    pulse(P_ACC);  step(2);

    // R7 master transmit deferred STOP
    pulse(P_STOP); chk("R7 held", stop, 0); chk("R7 pend", stop_pend, 1);
    btf = 1;
    step(2);       chk("R7 btf only", stop, 0);
    pulse(P_EOT);  chk("R7 eot edge", stop, 0);
    step(1);       chk("R7 stop", stop, 1); chk("R7 pend clr", stop_pend, 0);
    step(1);       chk("R7 one cycle", stop, 0);
    btf = 0;
    pulse(P_ACLR);

    // R8 other modes
    dma_en = 0; addr = 1;
    pulse(P_STOP); chk("R8 held", stop, 0); chk("R8 pend", stop_pend, 1);
    step(1);       chk("R8 still", stop, 0);
    addr = 0;
    step(1);       chk("R8 released", stop, 1);
    step(1);       chk("R8 one cycle", stop, 0);
    pulse(P_STOP); chk("R8 direct", stop, 1);

    // R5 receive last byte
    tx = 0; dma_en = 1; last = 1; ack = 1;
    pulse(P_RXNE); chk("R1 rx req", dma_req, 1);
    pulse(P_ACC);  step(2);
    pulse(P_EOT1); chk("R5 nack", ack_o, 0);
    step(2);       chk("R5 nack hold", ack_o, 0);
    pulse(P_ACLR); chk("R5 nack clr", ack_o, 1);
    last = 0;
    pulse(P_EOT1); chk("R5 last off", ack_o, 1);
    // R6 single byte: ACK cleared during ADDR
    addr = 1; ack = 0; #1;
    chk("R6 single nack", ack_o, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule